// File: doc/BRIEF.md
# Streaming 2x2 Gradient Edge-Strength Unit

This block turns a raster stream of already-smoothed 8-bit pixels into a stream of edge strengths. Each input word carries four horizontally adjacent pixels. The block keeps the previous line in a word-wide line memory, together with the last pixel of the previous word on both the current and the previous line. From these it forms, for every pixel, a 2x2 window made of the pixel itself, its left neighbour, the pixel above and the pixel above-left. Two sum/difference derivatives are taken over that window. The output for the pixel is the sum of their absolute values, clipped to 8 bits. The four lanes of a word are computed side by side in the same cycle.

Both stream edges use valid/ready. An input word is taken in a cycle where `in_valid` and `in_ready` are both high. A result word is taken in a cycle where `out_valid` and `out_ready` are both high. The block has one output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle, so a continuously ready sink receives one word per clock. While the sink holds `out_ready` low, the output holds still and no new input is taken. Line and frame structure travel as markers on the data words. A pixel that has no full window, because it lies in the first line of a frame or the first column of a line, yields zero and raises its border flag.

Top module: `edge_l1_grad`

## Requirements
- R1: An input word is accepted exactly when `in_valid` and `in_ready` are high at a rising clock edge. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. The result of an accepted word appears on the output at the next edge. After reset, `out_valid` is low and `in_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof`, `out_eol` and `out_border` keep their values at the next edge.
- R3: Byte lane k (bits 8k+7..8k) of input word w of a line holds the pixel in column 4w+k. Output lane k of the matching result word holds that pixel's magnitude, and `out_border[k]` holds that pixel's border flag. The left neighbour of lane 0 is lane 3 of the previous word of the same line, and the same relation holds for the line above.
- R4: The horizontal response is gx = (above + current) - (above-left + left).
- R5: The vertical response is gy = (left + current) - (above-left + above).
- R6: Each non-border output lane equals |gx| + |gy| when that sum is at most 255, and equals 255 otherwise.
- R7: Every lane of every word in the first line of a frame outputs 0 with its border bit set. The first line runs from the word marked `in_sof` up to and including the first word marked `in_eol`.
- R8: Lane 0 of the first word of every later line outputs 0 with `out_border[0]` set. All other lanes outside the first line have their border bit clear.
- R9: `out_sof` and `out_eol` of a result word equal `in_sof` and `in_eol` of the input word it came from.
- R10: A word marked `in_sof` restarts at line 0, column 0, even when it arrives in the middle of a line. A line holds at most WIDTH pixels, where WIDTH is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | 32 | Four smoothed pixels, lane k = column 4w+k |
| in_sof | input | 1 | Word is the first of a frame |
| in_eol | input | 1 | Word is the last of a line |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Sink takes the result word this cycle |
| out_data | output | 32 | Four saturated L1 magnitudes |
| out_sof | output | 1 | Start-of-frame marker of the source word |
| out_eol | output | 1 | End-of-line marker of the source word |
| out_border | output | 4 | Per-lane flag: no full 2x2 window, value forced to 0 |

## Verification
Two things can land in the same cycle: a sink stall, and an input word that is ready to update the line memory and the held neighbour pixels. If a stalled word were still absorbed, the next word would be computed against wrong neighbours. To provoke this, `out_ready` is toggled pseudo-randomly while input words are kept pending, some of them idle-separated and some back to back. Every held output is judged for stability, and every later result is compared lane by lane against a behavioural model, so an absorbed or lost word shows up as a wrong neighbour value or a shifted marker.

// File: rtl/edge_l1_pkg.sv
package edge_l1_pkg;
  localparam int PIX_W_DEF = 8;
  localparam int LANES_DEF = 4;

  typedef struct packed {
    logic sof;
    logic eol;
  } edge_mark_t;
endpackage

// File: rtl/edge_l1_linemem.sv
module edge_l1_linemem #(
  parameter int DEPTH = 160,
  parameter int W     = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read returns the stored line above; a same-cycle write lands at the edge
  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/edge_l1_lane.sv
module edge_l1_lane #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] ul,
  input  logic [PW-1:0] up,
  input  logic [PW-1:0] lf,
  input  logic [PW-1:0] cur,
  input  logic          border,
  output logic [PW-1:0] mag
);
  localparam int SW   = PW + 3;
  localparam int MAXV = (1 << PW) - 1;

  logic signed [SW-1:0] gx, gy, ax, ay;
  logic [SW-1:0] sum;

  always_comb begin
    gx  = $signed({3'b000, up}) + $signed({3'b000, cur})
        - $signed({3'b000, ul}) - $signed({3'b000, lf});
    gy  = $signed({3'b000, lf}) + $signed({3'b000, cur})
        - $signed({3'b000, ul}) - $signed({3'b000, up});
    ax  = (gx < 0) ? -gx : gx;
    ay  = (gy < 0) ? -gy : gy;
    sum = $unsigned(ax) + $unsigned(ay);
    if (border)                sum = '0;
    if (sum > SW'(MAXV))       mag = PW'(MAXV);
    else                       mag = sum[PW-1:0];
  end
endmodule

// File: rtl/edge_l1_grad.sv
module edge_l1_grad
  import edge_l1_pkg::*;
#(
  parameter int WIDTH = 640,
  parameter int PIX_W = PIX_W_DEF,
  parameter int LANES = LANES_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W*LANES-1:0] in_data,
  input  logic                   in_sof,
  input  logic                   in_eol,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W*LANES-1:0] out_data,
  output logic                   out_sof,
  output logic                   out_eol,
  output logic [LANES-1:0]       out_border
);
  localparam int DW    = PIX_W * LANES;
  localparam int WORDS = WIDTH / LANES;
  localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             accept;
  logic [CW-1:0]    col_q, col_idx;
  logic             row0_q, row_first;
  logic [PIX_W-1:0] left_cur_q, left_top_q;
  logic [DW-1:0]    top_word;
  logic [PIX_W-1:0] ext_cur [LANES+1];
  logic [PIX_W-1:0] ext_top [LANES+1];
  logic [DW-1:0]    mag_word;
  logic [LANES-1:0] border_vec;
  edge_mark_t       mark_in;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign col_idx   = in_sof ? '0 : col_q;
  assign row_first = in_sof ? 1'b1 : row0_q;
  assign mark_in   = '{sof: in_sof, eol: in_eol};

  edge_l1_linemem #(.DEPTH(WORDS), .W(DW), .AW(CW)) u_line (
    .clk   (clk),
    .we    (accept),
    .waddr (col_idx),
    .wdata (in_data),
    .raddr (col_idx),
    .rdata (top_word)
  );

  // window columns: index 0 is the pixel left of lane 0, index i+1 is lane i
  always_comb begin
    ext_cur[0] = left_cur_q;
    ext_top[0] = left_top_q;
    for (int i = 0; i < LANES; i++) begin
      ext_cur[i+1] = in_data[i*PIX_W +: PIX_W];
      ext_top[i+1] = top_word[i*PIX_W +: PIX_W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_first
      assign border_vec[g] = row_first || (col_idx == '0);
    end else begin : g_rest
      assign border_vec[g] = row_first;
    end
    edge_l1_lane #(.PW(PIX_W)) u_lane (
      .ul     (ext_top[g]),
      .up     (ext_top[g+1]),
      .lf     (ext_cur[g]),
      .cur    (ext_cur[g+1]),
      .border (border_vec[g]),
      .mag    (mag_word[g*PIX_W +: PIX_W])
    );
  end

  // position and neighbour state advance only on accepted words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q      <= '0;
      row0_q     <= 1'b1;
      left_cur_q <= '0;
      left_top_q <= '0;
    end else if (accept) begin
      left_cur_q <= in_data[DW-1 -: PIX_W];
      left_top_q <= top_word[DW-1 -: PIX_W];
      if (in_eol) begin
        col_q  <= '0;
        row0_q <= 1'b0;
      end else begin
        col_q  <= col_idx + 1'b1;
        row0_q <= row_first;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sof    <= 1'b0;
      out_eol    <= 1'b0;
      out_border <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_data   <= mag_word;
      out_sof    <= mark_in.sof;
      out_eol    <= mark_in.eol;
      out_border <= border_vec;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (int'(col_idx) < WORDS)); // R10

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_border)
                                   && $stable(out_sof) && $stable(out_eol))); // R2

  AST_SOF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sof) |=> (out_valid && out_sof)); // R9

  AST_EOL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eol) |=> (out_valid && out_eol)); // R9

  AST_SOF_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_border == '1 && out_data == '0)); // R7

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R1
endmodule

// File: tb/edge_l1_grad_test.sv
module edge_l1_grad_test;
  localparam int PERIOD = 10;
  localparam int WIDTH  = 16;
  localparam int WPL    = WIDTH / 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_sof = 0;
  logic        in_eol = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_data;
  logic        out_sof, out_eol;
  logic [3:0]  out_border;

  int checks = 0;
  int fails  = 0;
  int n_acc  = 0;
  int n_out  = 0;
  bit bp_mode = 0;
  bit restart = 0;

  // reference model state
  int prev_row [WIDTH];
  int cur_row  [WIDTH];
  int m_row = 0;
  int m_col = 0;
  logic [37:0] exp_q [$];
  int          tag_q [$];

  edge_l1_grad #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .out_border(out_border)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic string tagname(int c);
    case (c)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R10";
      default: return "R3";
    endcase
  endfunction

  function automatic void check(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endfunction

  function automatic void model_accept(logic [31:0] d, logic s, logic e);
    logic [31:0] mw;
    logic [3:0]  bw;
    int tags, a, b, c, p, gx, gy, sum;
    mw = '0; bw = '0; tags = 0;
    if (s) begin m_row = 0; m_col = 0; end
    for (int k = 0; k < 4; k++) cur_row[m_col*4+k] = int'(d[8*k +: 8]);
    for (int k = 0; k < 4; k++) begin
      int x, code, mag;
      x = m_col*4 + k;
      if (m_row == 0) begin
        mag = 0; bw[k] = 1; code = restart ? 6 : 4;
      end else if (x == 0) begin
        mag = 0; bw[k] = 1; code = 5;
      end else begin
        a = prev_row[x-1]; b = prev_row[x]; c = cur_row[x-1]; p = cur_row[x];
        gx = (b + p) - (a + c);
        gy = (c + p) - (a + b);
        sum = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        mag = (sum > 255) ? 255 : sum;
        code = (sum > 255) ? 3 : (gy == 0) ? 1 : (gx == 0) ? 2 : 0;
      end
      mw[8*k +: 8] = mag[7:0];
      tags |= code << (4*k);
    end
    exp_q.push_back({mw, s, e, bw});
    tag_q.push_back(tags);
    if (e) begin
      for (int i = 0; i < WIDTH; i++) prev_row[i] = cur_row[i];
      m_row++; m_col = 0;
    end else m_col++;
  endfunction

  task automatic send(input logic [31:0] d, input logic s, input logic e);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_data = d; in_sof = s; in_eol = e;
      #1;
      if (in_ready) begin
        model_accept(d, s, e);
        n_acc++;
        done = 1;
      end
    end
    if (bp_mode && ($urandom % 4 == 0)) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  // pat: 0 random, 1 vertical stripes, 2 horizontal stripes, 3 diagonal step
  function automatic int pix(int pat, int r, int x);
    case (pat)
      1: return (x % 2) ? 160 : 100;
      2: return (r % 2) ? 170 : 90;
      3: return (x + r >= 9) ? 255 : 0;
      default: return int'($urandom % 256);
    endcase
  endfunction

  task automatic frame(input int pat, input int lines, input int partial_words);
    for (int r = 0; r < lines; r++) begin
      for (int w = 0; w < WPL; w++) begin
        logic [31:0] d;
        if (r == lines-1 && partial_words > 0 && w >= partial_words) break;
        for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(pix(pat, r, w*4+k));
        send(d, (r == 0 && w == 0), (w == WPL-1));
        if (r == 0 && w == WPL-1) restart = 0;
      end
    end
  endtask

  // output ready pattern, changed on the falling edge only
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // monitor: sampled after both drivers settle, before the next rising edge
  logic [37:0] held;
  bit          was_stall = 0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (was_stall) begin
          check(out_valid === 1'b1 && {out_data, out_sof, out_eol, out_border} === held,
                "R2", int'(out_data), int'(held[37:6]), "stalled output held");
        end
        was_stall = out_valid && !out_ready;
        held = {out_data, out_sof, out_eol, out_border};
        if (out_valid && out_ready) begin
          n_out++;
          if (exp_q.size() == 0) begin
            check(0, "R1", 1, 0, "unexpected output word");
          end else begin
            logic [37:0] ex;
            int tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            for (int k = 0; k < 4; k++) begin
              string t;
              t = tagname((tg >> (4*k)) & 15);
              check(out_data[8*k +: 8] === ex[6+8*k +: 8], t,
                    int'(out_data[8*k +: 8]), int'(ex[6+8*k +: 8]), "lane magnitude");
              check(out_border[k] === ex[k], (tg >> (4*k) & 15) >= 4 ? t : "R8",
                    int'(out_border[k]), int'(ex[k]), "lane border flag");
            end
            check(out_sof === ex[5], "R9", int'(out_sof), int'(ex[5]), "sof marker");
            check(out_eol === ex[4], "R9", int'(out_eol), int'(ex[4]), "eol marker");
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    check(out_valid === 1'b0, "R1", int'(out_valid), 0, "reset out_valid");
    check(in_ready === 1'b1, "R1", int'(in_ready), 1, "reset in_ready");

    frame(0, 5, 0);          // random content, full rate (R3)
    frame(1, 3, 0);          // vertical stripes: only gx (R4)
    frame(2, 4, 0);          // horizontal stripes: only gy (R5)
    bp_mode = 1;
    frame(3, 5, 0);          // diagonal step, saturating corners (R6) under stalls
    frame(0, 3, 2);          // partial last line, then restart
    restart = 1;
    frame(0, 4, 0);          // sof arrives mid-line (R10)
    frame(3, 3, 0);
    bp_mode = 0;
    idle(8);
    check(exp_q.size() == 0, "R1", exp_q.size(), 0, "pending results after drain");
    check(n_out == n_acc, "R1", n_out, n_acc, "output count equals accepted count");
    finish_run();
  end
endmodule